// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Device Identification

This block is the serial test port of a memory device. A four-wire serial interface (test clock, mode select, data in, data out) steps a sixteen-state controller. The controller moves data through either a three-bit instruction register or one of three data paths:
- a 32-bit identification word;
- a single bypass bit;
- a boundary register of parameterised length that captures the device's pin values.

The instructions are:
- IDCODE, which selects the identification path.
- EXTEST and SAMPLE, which both select the boundary path. The boundary register only captures pin values; no preload data is ever applied to pins.
- BYPASS, which selects the bypass bit.

Any other code also selects the bypass bit.

A board-level tester drives the mode-select line to walk the controller through capture, shift, pause and update states. Serial data is shifted least-significant bit first. The data output changes on the falling test-clock edge. An output-enable pin marks the cycles in which the pad must drive. At all other times the pad floats.

Top module: `scan_tap_port`

## Requirements
- R1: After power-on reset the active instruction is IDCODE (code 3'b001), so a data scan with no prior instruction scan returns the identification word, bit 0 first.
- R2: Five consecutive rising test-clock edges with mode select high bring the controller to Test-Logic-Reset from any state.
- R3: While the controller is in Test-Logic-Reset, the active instruction is reloaded with IDCODE, replacing any instruction loaded before.
- R4: Capture-IR loads 3'b001 into the instruction shift stage, so the first three bits shifted out of an instruction scan are 1, 0, 0.
- R5: A shifted-in instruction becomes active only on the rising edge taken in Update-IR. Codes are EXTEST 3'b000, IDCODE 3'b001, SAMPLE 3'b100 and BYPASS 3'b111.
- R6: BYPASS places one register bit between data in and data out. It captures 0, so a data scan returns 0 and then the input bits delayed by one position.
- R7: The reserved codes 3'b010, 3'b011, 3'b101 and 3'b110 behave exactly as BYPASS.
- R8: The identification word carries revision in bits 31:29, depth in bits 28:24, width in bits 23:18, device number in bits 17:12 and vendor code in bits 11:1, with bit 0 fixed at 1.
- R9: With SAMPLE or EXTEST active, Capture-DR loads the parallel pin values into the boundary register, bit i from pin i. Positions flagged as unbonded by a parameter mask are captured as 1 whatever their pin carries.
- R10: Leaving a data scan through Pause-DR and Exit2-DR back to Shift-DR resumes the shift without a new capture. Update-DR changes no register, so it has the same effect as passing through Pause-DR.
- R11: The output enable is high only while the controller is in Shift-IR or Shift-DR. The data output and the enable change only on the falling test-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| pwr_rst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on the rising test-clock edge |
| tdi | input | 1 | Serial data in, sampled on the rising test-clock edge |
| pins | input | BSR_LEN | Parallel pin values captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on the falling test-clock edge |
| tdo_oe | output | 1 | Pad drive enable for tdo; low means the pad floats |

## Verification
The bench targets the following corner cases:
- **Five-ones reset from the middle of a bypass scan.** A controller that needs more edges, or that keeps the old instruction, returns a one-bit path instead of the identification word.
- **The capture pattern of the instruction shift stage.** A design that captures the active instruction instead returns that instruction's bits.
- **Pause-and-resume inside a data scan.** A design that recaptures on Exit2-DR repeats the low bits of the word.
- **Reserved codes and unbonded boundary positions.** A design that decodes reserved codes to another path, or that passes raw pin values at unbonded positions, shows a wrong scan length or wrong bits.

Random instruction codes, pin values and shift data then cover every path against expected scan streams computed by the bench.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_ID,
        PATH_BSR
    } dr_path_e;

    function automatic tap_state_e tap_next(input tap_state_e cur, input logic m);
        tap_state_e nx;
        case (cur)
            ST_TLR:    nx = m ? ST_TLR    : ST_RTI;
            ST_RTI:    nx = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nx = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nx = m ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nx = m ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nx = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nx = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nx = m ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nx = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nx = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nx = m ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nx = m ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nx = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nx = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nx = m ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nx = m ? ST_SEL_DR : ST_RTI;
            default:   nx = ST_TLR;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/tap_ctrl_fsm.sv
module tap_ctrl_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = tap_next(r_q.st, tms);
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_TLR};
        else        r_q <= r_d;
    end

    assign state = r_q.st;

    // R2
    five_ones_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state == ST_TLR));

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_tdo,
    output dr_path_e   path
);

    typedef struct packed {
        logic [IR_W-1:0] shift;
        logic [IR_W-1:0] active;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_TLR:    r_d.active = OP_IDCODE;
            ST_CAP_IR: r_d.shift  = IR_CAPTURE;
            ST_SHF_IR: r_d.shift  = {tdi, r_q.shift[IR_W-1:1]};
            ST_UPD_IR: r_d.active = r_q.shift;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{shift: IR_CAPTURE, active: OP_IDCODE};
        else        r_q <= r_d;
    end

    always_comb begin
        case (r_q.active)
            OP_IDCODE:             path = PATH_ID;
            OP_EXTEST, OP_SAMPLE:  path = PATH_BSR;
            default:               path = PATH_BYP;
        endcase
    end

    assign ir_tdo = r_q.shift[0];

    // R3
    tlr_loads_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_TLR) |=> (r_q.active == OP_IDCODE));

    // R4
    capture_pattern_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> (r_q.shift[1:0] == 2'b01));

    // R5
    instr_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !(state == ST_UPD_IR || state == ST_TLR) |=> $stable(r_q.active));

endmodule

// File: rtl/tap_data_regs.sv
module tap_data_regs
    import scan_tap_pkg::*;
#(
    parameter int                 BSR_LEN   = 8,
    parameter logic [BSR_LEN-1:0] UNBONDED  = '0,
    parameter logic [2:0]         REV_ID    = 3'd1,
    parameter logic [4:0]         DEPTH_ID  = 5'd9,
    parameter logic [5:0]         WIDTH_ID  = 6'd3,
    parameter logic [5:0]         DEV_ID    = 6'd21,
    parameter logic [10:0]        VENDOR_ID = 11'h1C5
) (
    input  logic               tck,
    input  logic               rst_n,
    input  tap_state_e         state,
    input  dr_path_e           path,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins,
    output logic               dr_tdo
);

    localparam int          ID_W    = 32;
    localparam logic [31:0] ID_WORD = {REV_ID, DEPTH_ID, WIDTH_ID, DEV_ID, VENDOR_ID, 1'b1};

    typedef struct packed {
        logic [ID_W-1:0]    id_sh;
        logic               byp;
        logic [BSR_LEN-1:0] bsr;
    } dr_regs_t;

    dr_regs_t r_d, r_q;
    logic [BSR_LEN-1:0] bsr_cap;

    for (genvar gi = 0; gi < BSR_LEN; gi++) begin : g_cap
        if (UNBONDED[gi]) begin : g_tie
            assign bsr_cap[gi] = 1'b1;
        end else begin : g_pin
            assign bsr_cap[gi] = pins[gi];
        end
    end

    always_comb begin
        r_d = r_q;
        if (state == ST_CAP_DR) begin
            case (path)
                PATH_ID:  r_d.id_sh = ID_WORD;
                PATH_BSR: r_d.bsr   = bsr_cap;
                default:  r_d.byp   = 1'b0;
            endcase
        end else if (state == ST_SHF_DR) begin
            case (path)
                PATH_ID:  r_d.id_sh = {tdi, r_q.id_sh[ID_W-1:1]};
                PATH_BSR: r_d.bsr   = (BSR_LEN > 1) ? {tdi, r_q.bsr[BSR_LEN-1:1]} : tdi;
                default:  r_d.byp   = tdi;
            endcase
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{id_sh: ID_WORD, byp: 1'b0, bsr: UNBONDED};
        else        r_q <= r_d;
    end

    always_comb begin
        case (path)
            PATH_ID:  dr_tdo = r_q.id_sh[0];
            PATH_BSR: dr_tdo = r_q.bsr[0];
            default:  dr_tdo = r_q.byp;
        endcase
    end

    // R6
    bypass_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && path == PATH_BYP) |=> (r_q.byp == 1'b0));

    // R9
    unbonded_one_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && path == PATH_BSR) |=> ((r_q.bsr & UNBONDED) == UNBONDED));

    // R10
    update_no_effect_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_UPD_DR || state == ST_PAU_DR || state == ST_EX2_DR) |=> $stable(r_q));

endmodule

// File: rtl/scan_tap_port.sv
module scan_tap_port
    import scan_tap_pkg::*;
#(
    parameter int                 BSR_LEN   = 8,
    parameter logic [BSR_LEN-1:0] UNBONDED  = 8'h21,
    parameter logic [2:0]         REV_ID    = 3'd1,
    parameter logic [4:0]         DEPTH_ID  = 5'd9,
    parameter logic [5:0]         WIDTH_ID  = 6'd3,
    parameter logic [5:0]         DEV_ID    = 6'd21,
    parameter logic [10:0]        VENDOR_ID = 11'h1C5
) (
    input  logic               tck,
    input  logic               pwr_rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins,
    output logic               tdo,
    output logic               tdo_oe
);

    tap_state_e state;
    dr_path_e   path;
    logic       ir_tdo;
    logic       dr_tdo;

    tap_ctrl_fsm u_fsm (
        .tck   (tck),
        .rst_n (pwr_rst_n),
        .tms   (tms),
        .state (state)
    );

    tap_instr_reg u_ir (
        .tck    (tck),
        .rst_n  (pwr_rst_n),
        .state  (state),
        .tdi    (tdi),
        .ir_tdo (ir_tdo),
        .path   (path)
    );

    tap_data_regs #(
        .BSR_LEN   (BSR_LEN),
        .UNBONDED  (UNBONDED),
        .REV_ID    (REV_ID),
        .DEPTH_ID  (DEPTH_ID),
        .WIDTH_ID  (WIDTH_ID),
        .DEV_ID    (DEV_ID),
        .VENDOR_ID (VENDOR_ID)
    ) u_dr (
        .tck    (tck),
        .rst_n  (pwr_rst_n),
        .state  (state),
        .path   (path),
        .tdi    (tdi),
        .pins   (pins),
        .dr_tdo (dr_tdo)
    );

    typedef struct packed {
        logic dout;
        logic oe;
    } out_regs_t;

    out_regs_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        o_d.oe   = (state == ST_SHF_IR) || (state == ST_SHF_DR);
        if (state == ST_SHF_IR)      o_d.dout = ir_tdo;
        else if (state == ST_SHF_DR) o_d.dout = dr_tdo;
    end

    always_ff @(negedge tck or negedge pwr_rst_n) begin
        if (!pwr_rst_n) o_q <= '{dout: 1'b0, oe: 1'b0};
        else            o_q <= o_d;
    end

    assign tdo    = o_q.dout;
    assign tdo_oe = o_q.oe;

    // R11
    drive_window_chk: assert property (@(posedge tck) disable iff (!pwr_rst_n)
        tdo_oe == ((state == ST_SHF_IR) || (state == ST_SHF_DR)));

endmodule

// File: tb/scan_tap_port_bench.sv
module scan_tap_port_bench;

    localparam int          TCK_PERIOD = 20;
    localparam int          BSR_LEN    = 8;
    localparam logic [7:0]  UNB_MASK   = 8'h21;
    localparam logic [31:0] EXP_ID     = {3'd1, 5'd9, 6'd3, 6'd21, 11'h1C5, 1'b1};

    logic               tck = 1'b0;
    logic               pwr_rst_n = 1'b0;
    logic               tms = 1'b1;
    logic               tdi = 1'b0;
    logic [BSR_LEN-1:0] pins = '0;
    logic               tdo;
    logic               tdo_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    scan_tap_port #(.BSR_LEN(BSR_LEN), .UNBONDED(UNB_MASK)) u_scan_tap_port (
        .tck       (tck),
        .pwr_rst_n (pwr_rst_n),
        .tms       (tms),
        .tdi       (tdi),
        .pins      (pins),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        #(TCK_PERIOD / 4) tck = 1'b1;
        #(TCK_PERIOD / 2) tck = 1'b0;
        #(TCK_PERIOD / 4);
    endtask

    task automatic go_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            cap[i] = tdo;
            step(i == 2, code[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout, output bit oe_ok);
        dout  = '0;
        oe_ok = 1;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (!tdo_oe) oe_ok = 0;
            step(i == n - 1, din[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    function automatic logic [63:0] expect_scan(input int len, input logic [63:0] cap,
                                                input logic [63:0] din, input int n);
        logic [63:0] e = '0;
        for (int i = 0; i < n; i++) e[i] = (i < len) ? cap[i] : din[i - len];
        return e;
    endfunction

    function automatic logic [63:0] low_bits(input logic [63:0] v, input int n);
        return (n >= 64) ? v : (v & ((64'd1 << n) - 64'd1));
    endfunction

    initial begin
        #(TCK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0]  cap;
        logic [63:0] dout;
        logic [63:0] din;
        bit          ok;
        void'($urandom(32'd7321));

        #(TCK_PERIOD);
        pwr_rst_n = 1'b1;
        #(TCK_PERIOD / 2);
        // R11: pad floats after reset
        check(tdo_oe == 1'b0, "R11 reset oe", tdo_oe, 0);
        step(0, 0);

        // R1: identification word readable straight after power-on
        din = 64'h0;
        scan_dr(40, din, dout, ok);
        check(low_bits(dout, 40) == expect_scan(32, EXP_ID, din, 40), "R1 idcode after reset",
              dout, expect_scan(32, EXP_ID, din, 40));
        // R11: enable held through the shift
        check(ok, "R11 oe during shift", ok, 1);
        check(tdo_oe == 1'b0, "R11 oe idle", tdo_oe, 0);
        // R8: field layout
        check(dout[0] == 1'b1 && dout[31:29] == 3'd1 && dout[28:24] == 5'd9 &&
              dout[23:18] == 6'd3 && dout[17:12] == 6'd21 && dout[11:1] == 11'h1C5,
              "R8 id fields", dout[31:0], EXP_ID);

        // R4: capture pattern shifted out during instruction scan; R5 bypass becomes active
        load_ir(3'b111, cap);
        check(cap == 3'b001, "R4 capture-ir pattern", cap, 3'b001);
        din = 64'h0000_0000_0000_00B6;
        scan_dr(9, din, dout, ok);
        check(low_bits(dout, 9) == expect_scan(1, 0, din, 9), "R5 R6 bypass path",
              dout, expect_scan(1, 0, din, 9));

        // R2 R3: five ones from the middle of a bypass scan
        step(1, 0); step(0, 0); step(0, 0);
        step(0, 1); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        din = 64'h0;
        scan_dr(33, din, dout, ok);
        check(low_bits(dout, 33) == expect_scan(32, EXP_ID, din, 33), "R2 R3 reset restores idcode",
              dout, expect_scan(32, EXP_ID, din, 33));

        // R7: each reserved code acts as a single bypass bit
        for (int c = 0; c < 8; c++) begin
            if (c == 2 || c == 3 || c == 5 || c == 6) begin
                load_ir(c[2:0], cap);
                din = 64'h0000_0000_0000_003D;
                scan_dr(7, din, dout, ok);
                check(low_bits(dout, 7) == expect_scan(1, 0, din, 7), "R7 reserved code",
                      dout, expect_scan(1, 0, din, 7));
            end
        end

        // R9: sample with unbonded positions forced
        pins = 8'h00;
        load_ir(3'b100, cap);
        din = 64'h0;
        scan_dr(8, din, dout, ok);
        check(dout[7:0] == UNB_MASK, "R9 unbonded read 1", dout[7:0], UNB_MASK);
        pins = 8'hDE;
        load_ir(3'b000, cap);
        scan_dr(12, din, dout, ok);
        check(low_bits(dout, 12) == expect_scan(8, 8'hDE | UNB_MASK, din, 12), "R9 extest capture",
              dout, expect_scan(8, 8'hDE | UNB_MASK, din, 12));

        // R10: pause and resume in a data scan without recapture
        load_ir(3'b001, cap);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            dout[i] = tdo;
            step(i == 3, 0);
        end
        step(0, 0); step(1, 0); step(0, 0);
        for (int i = 4; i < 8; i++) begin
            dout[i] = tdo;
            step(i == 7, 0);
        end
        step(1, 0); step(0, 0);
        check(dout[7:0] == EXP_ID[7:0], "R10 pause resume", dout[7:0], EXP_ID[7:0]);

        // R10: update-dr leaves the shifted value alone, next scan recaptures pins
        pins = 8'h5A;
        load_ir(3'b100, cap);
        din = 64'hFF;
        scan_dr(8, din, dout, ok);
        din = 64'h0;
        scan_dr(8, din, dout, ok);
        check(dout[7:0] == (8'h5A | UNB_MASK), "R10 update no preload", dout[7:0], 8'h5A | UNB_MASK);

        // R5 R6 R7 R8 R9: random instructions, pins and data
        for (int it = 0; it < 40; it++) begin
            logic [2:0]  code;
            logic [63:0] capv;
            logic [63:0] expv;
            int          len;
            code = 3'($urandom % 8);
            pins = 8'($urandom);
            din  = {$urandom, $urandom};
            load_ir(code, cap);
            if (code == 3'b001) begin
                len = 32; capv = {32'h0, EXP_ID};
            end else if (code == 3'b000 || code == 3'b100) begin
                len = 8;  capv = {56'h0, pins | UNB_MASK};
            end else begin
                len = 1;  capv = 64'h0;
            end
            scan_dr(len + 8, din, dout, ok);
            expv = expect_scan(len, capv, din, len + 8);
            check(low_bits(dout, len + 8) == expv && ok, "R5 random scan", dout, expv);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule